// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address that missed in the translation buffer. It walks a two-level table held in memory. The top 10 bits of the address index a first-level table, the next 10 bits index a second-level table, and the low 12 bits pass through untranslated. Every entry is one 32-bit word, so a single 4 KB page holds 1024 entries. The walker reads one word per level over a plain request/response port and reports the result with a single-cycle strobe. A good result is the physical address with two permission bits. A failed walk is a page fault tagged with the level where it stopped.

A walk begins when `walk_req_i` is high while the walker is idle. The walker captures the virtual address and the table base at that edge. The first read goes to the base plus four times the first-level index. If that entry is marked present, its frame number shifted left by 12 locates the second-level table. The second read goes to that location plus four times the second-level index. A cleared present bit at either level ends the walk at once with a fault.

Top module: `ptw_walker`

## Requirements
- R1: While reset is low and after it is released, `walk_ready_o` is 1 and `mem_req_o`, `done_o` and `fault_o` are 0.
- R2: One cycle after a request is accepted in idle, `mem_req_o` is 1 and `mem_addr_o` equals the captured base plus VA[31:22] times 4.
- R3: The second read addresses {L1 entry bits 31:12, 12'h000} plus VA[21:12] times 4.
- R4: An L1 entry with bit 0 (present) equal to 0 ends the walk with `fault_o`=1 and `fault_lvl_o`=1, and no second read is issued. The entry's other bits do not matter.
- R5: An L2 entry with bit 0 equal to 0 ends the walk with `fault_o`=1 and `fault_lvl_o`=2.
- R6: A present L2 entry ends the walk with `fault_o`=0, `fault_lvl_o`=0, `pa_o` = {entry bits 31:12, VA[11:0]}, `perm_wr_o` = entry bit 1 and `perm_dirty_o` = entry bit 2.
- R7: `walk_req_i` has no effect while a walk is in progress. The walk in flight uses only the address and base captured when it was accepted.
- R8: `mem_rvalid_i` is ignored outside the two response-wait phases. This covers idle and the cycle in which a read is issued.
- R9: Each read is a one-cycle `mem_req_o` pulse. Exactly one read is issued per level visited.
- R10: `done_o` is high for exactly one cycle per walk, and `walk_ready_o` returns to 1 in the next cycle. `walk_ready_o` stays 0 from acceptance to that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| walk_req_i | input | 1 | Start a walk (taken only when idle) |
| walk_va_i | input | 32 | Virtual address to translate |
| pt_base_i | input | 32 | Start address of the first-level table |
| walk_ready_o | output | 1 | Walker idle, a request will be taken |
| mem_req_o | output | 1 | One-cycle word read request |
| mem_addr_o | output | 32 | Byte address of the entry read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Entry word returned |
| done_o | output | 1 | One-cycle end-of-walk strobe |
| fault_o | output | 1 | Walk ended in a page fault |
| fault_lvl_o | output | 2 | Level of the fault (1 or 2), 0 on success |
| pa_o | output | 32 | Translated physical address |
| perm_wr_o | output | 1 | Write permission from the leaf entry |
| perm_dirty_o | output | 1 | Dirty flag from the leaf entry |

## Verification
The walker is driven through successful walks with different indices, including the top index 1023 at both levels and offset 0xFFF. These show whether each index is scaled and whether the second table base comes from the right field. Walks that fault at level one and at level two separate the two stop points. A non-present first-level entry with every other bit set shows that only the present bit decides the outcome. Response latencies of one, two and three cycles, requests raised mid-walk, and response pulses in idle and in the issue cycle show that the walker reacts only to accepted requests and to data it is waiting for.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD1   = 3'd1,
    ST_WT1   = 3'd2,
    ST_RD2   = 3'd3,
    ST_WT2   = 3'd4,
    ST_DONE  = 3'd5,
    ST_FAULT = 3'd6
  } walk_state_e;

  localparam int unsigned PTE_V_BIT = 0;
  localparam int unsigned PTE_W_BIT = 1;
  localparam int unsigned PTE_D_BIT = 2;

  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_ONE  = 2'd1;
  localparam logic [1:0] LVL_TWO  = 2'd2;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned PA_W   = 32,
  parameter int unsigned L1_W   = 10,
  parameter int unsigned L2_W   = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned IDX_SH = 2,
  localparam int unsigned PPN_W = PA_W - OFF_W
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [L1_W-1:0]  idx1_i,
  input  logic [L2_W-1:0]  idx2_i,
  input  logic [PPN_W-1:0] tbl_ppn_i,
  input  logic             sel_l2_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [PA_W-1:0] off1, off2, tbl2_base;

  assign off1      = {{(PA_W-L1_W-IDX_SH){1'b0}}, idx1_i, {IDX_SH{1'b0}}};
  assign off2      = {{(PA_W-L2_W-IDX_SH){1'b0}}, idx2_i, {IDX_SH{1'b0}}};
  assign tbl2_base = {tbl_ppn_i, {OFF_W{1'b0}}};
  assign addr_o    = sel_l2_i ? (tbl2_base + off2) : (base_i + off1);
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned PPN_W = PTE_W - OFF_W
) (
  input  logic [PTE_W-1:0] pte_i,
  output logic             valid_o,
  output logic             wr_o,
  output logic             dirty_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic unused_rsvd;

  assign valid_o     = pte_i[PTE_V_BIT];
  assign wr_o        = pte_i[PTE_W_BIT];
  assign dirty_o     = pte_i[PTE_D_BIT];
  assign ppn_o       = pte_i[PTE_W-1 -: PPN_W];
  assign unused_rsvd = ^pte_i[OFF_W-1:PTE_D_BIT+1];
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        rvalid_i,
  input  logic        pte_valid_i,
  output walk_state_e state_o
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_RD1;
      ST_RD1:   state_d = ST_WT1;
      ST_WT1:   if (rvalid_i) state_d = pte_valid_i ? ST_RD2 : ST_FAULT;
      ST_RD2:   state_d = ST_WT2;
      ST_WT2:   if (rvalid_i) state_d = pte_valid_i ? ST_DONE : ST_FAULT;
      ST_DONE,
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned L1_W      = 10,
  parameter int unsigned L2_W      = 10,
  parameter int unsigned PTE_BYTES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            walk_req_i,
  input  logic [VA_W-1:0] walk_va_i,
  input  logic [PA_W-1:0] pt_base_i,
  output logic            walk_ready_o,
  output logic            mem_req_o,
  output logic [PA_W-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [PA_W-1:0] mem_rdata_i,
  output logic            done_o,
  output logic            fault_o,
  output logic [1:0]      fault_lvl_o,
  output logic [PA_W-1:0] pa_o,
  output logic            perm_wr_o,
  output logic            perm_dirty_o
);
  localparam int unsigned OFF_W  = VA_W - L1_W - L2_W;
  localparam int unsigned PPN_W  = PA_W - OFF_W;
  localparam int unsigned IDX_SH = $clog2(PTE_BYTES);

  walk_state_e     state;
  logic            accept, rsp1, rsp2;
  logic [VA_W-1:0] va_q;
  logic [PA_W-1:0] base_q;
  logic [PPN_W-1:0] tbl_ppn_q;
  logic            pte_valid, pte_wr, pte_dirty;
  logic [PPN_W-1:0] pte_ppn;
  logic [PA_W-1:0] pa_q;
  logic            wr_q, dirty_q;
  logic [1:0]      lvl_q;

  ptw_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (walk_req_i),
    .rvalid_i   (mem_rvalid_i),
    .pte_valid_i(pte_valid),
    .state_o    (state)
  );

  ptw_pte_decode #(.PTE_W(PA_W), .OFF_W(OFF_W)) i_dec (
    .pte_i  (mem_rdata_i),
    .valid_o(pte_valid),
    .wr_o   (pte_wr),
    .dirty_o(pte_dirty),
    .ppn_o  (pte_ppn)
  );

  ptw_addr_gen #(
    .PA_W(PA_W), .L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W), .IDX_SH(IDX_SH)
  ) i_agen (
    .base_i   (base_q),
    .idx1_i   (va_q[VA_W-1 -: L1_W]),
    .idx2_i   (va_q[OFF_W +: L2_W]),
    .tbl_ppn_i(tbl_ppn_q),
    .sel_l2_i (state == ST_RD2),
    .addr_o   (mem_addr_o)
  );

  assign accept = (state == ST_IDLE) && walk_req_i;
  assign rsp1   = (state == ST_WT1) && mem_rvalid_i;
  assign rsp2   = (state == ST_WT2) && mem_rvalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q      <= '0;
      base_q    <= '0;
      tbl_ppn_q <= '0;
    end else begin
      if (accept) begin
        va_q   <= walk_va_i;
        base_q <= pt_base_i;
      end
      if (rsp1 && pte_valid) tbl_ppn_q <= pte_ppn;
    end
  end

  // result held until the next walk ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q    <= '0;
      wr_q    <= 1'b0;
      dirty_q <= 1'b0;
      lvl_q   <= LVL_NONE;
    end else if (rsp1 && !pte_valid) begin
      lvl_q <= LVL_ONE;
    end else if (rsp2) begin
      if (pte_valid) begin
        pa_q    <= {pte_ppn, va_q[OFF_W-1:0]};
        wr_q    <= pte_wr;
        dirty_q <= pte_dirty;
        lvl_q   <= LVL_NONE;
      end else begin
        lvl_q <= LVL_TWO;
      end
    end
  end

  assign walk_ready_o = (state == ST_IDLE);
  assign mem_req_o    = (state == ST_RD1) || (state == ST_RD2);
  assign done_o       = (state == ST_DONE) || (state == ST_FAULT);
  assign fault_o      = (state == ST_FAULT);
  assign fault_lvl_o  = lvl_q;
  assign pa_o         = pa_q;
  assign perm_wr_o    = wr_q;
  assign perm_dirty_o = dirty_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       walk_req_i,
  input logic       walk_ready_o,
  input logic       mem_req_o,
  input logic       done_o,
  input logic       fault_o,
  input logic [1:0] fault_lvl_o
);
  a_r2_read_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_ready_o && walk_req_i |=> mem_req_o && !walk_ready_o);

  a_r4_fault_has_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> (fault_lvl_o == 2'd1 || fault_lvl_o == 2'd2));

  a_r6_ok_level_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> fault_lvl_o == 2'd0);

  a_r7_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !walk_ready_o && !done_o |=> !walk_ready_o);

  a_r9_req_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o && !done_o);

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && walk_ready_o);

  a_r10_fault_only_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);
endmodule

bind ptw_walker ptw_walker_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .walk_req_i  (walk_req_i),
  .walk_ready_o(walk_ready_o),
  .mem_req_o   (mem_req_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .fault_lvl_o (fault_lvl_o)
);

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_req = 1'b0;
  logic [31:0] walk_va = '0;
  logic [31:0] pt_base = '0;
  logic        walk_ready, mem_req, mem_rvalid, done, fault, perm_wr, perm_dirty;
  logic [31:0] mem_addr, mem_rdata, pa;
  logic [1:0]  fault_lvl;

  always #2.5 clk = ~clk;

  ptw_walker i_ptw_walker (
    .clk_i(clk), .rst_ni(rst_n), .walk_req_i(walk_req), .walk_va_i(walk_va),
    .pt_base_i(pt_base), .walk_ready_o(walk_ready), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .fault_lvl_o(fault_lvl), .pa_o(pa),
    .perm_wr_o(perm_wr), .perm_dirty_o(perm_dirty)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // memory image: absent words read as zero (not present)
  logic [31:0] mem [int unsigned];
  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] pte(input logic [19:0] ppn, input bit d, input bit w);
    return {ppn, 9'h0, d, w, 1'b1};
  endfunction

  // responder
  int          lat = 1;
  int          rsp_cnt = 0;
  logic [31:0] rsp_addr = '0;
  bit          stray = 1'b0;
  initial begin mem_rvalid = 1'b0; mem_rdata = '0; end

  always @(posedge clk) if (mem_req) begin rsp_cnt = lat; rsp_addr = mem_addr; end

  always @(negedge clk) begin
    #2;
    mem_rvalid = 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin mem_rvalid = 1'b1; mem_rdata = rd(rsp_addr); end
    end else if (stray) begin
      mem_rvalid = 1'b1;
      mem_rdata  = 32'hFFFF_F007;
      stray      = 1'b0;
    end
  end

  // cycle reference model: 0 idle,1 rd1,2 wait1,3 rd2,4 wait2,5 ok,6 fault
  int          ph = 0;
  int          m_lvl = 0;
  logic [31:0] m_va = '0, m_base = '0, m_e1 = '0, m_pa = '0;
  bit          m_w = 0, m_d = 0;

  always @(posedge clk) if (rst_n) begin
    case (ph)
      0: if (walk_req) begin m_va = walk_va; m_base = pt_base; ph = 1; end
      1: ph = 2;
      2: if (mem_rvalid) begin
           if (!mem_rdata[0]) begin ph = 6; m_lvl = 1; end
           else begin m_e1 = mem_rdata; ph = 3; end
         end
      3: ph = 4;
      4: if (mem_rvalid) begin
           if (!mem_rdata[0]) begin ph = 6; m_lvl = 2; end
           else begin
             ph = 5; m_lvl = 0;
             m_pa = {mem_rdata[31:12], m_va[11:0]};
             m_w = mem_rdata[1]; m_d = mem_rdata[2];
           end
         end
      default: ph = 0;
    endcase
  end

  always @(negedge clk) if (rst_n) begin
    chk(walk_ready == (ph == 0), "R10", "walk_ready", 32'(walk_ready), 32'(ph == 0));
    chk(mem_req == (ph == 1 || ph == 3), "R9", "mem_req", 32'(mem_req), 32'(ph == 1 || ph == 3));
    if (ph == 1)
      chk(mem_addr == m_base + {20'h0, m_va[31:22], 2'b00}, "R2", "l1 addr", mem_addr,
          m_base + {20'h0, m_va[31:22], 2'b00});
    if (ph == 3)
      chk(mem_addr == {m_e1[31:12], 12'h0} + {20'h0, m_va[21:12], 2'b00}, "R3", "l2 addr",
          mem_addr, {m_e1[31:12], 12'h0} + {20'h0, m_va[21:12], 2'b00});
    chk(done == (ph >= 5), "R10", "done", 32'(done), 32'(ph >= 5));
    if (ph == 6) begin
      chk(fault == 1'b1, (m_lvl == 1) ? "R4" : "R5", "fault", 32'(fault), 32'd1);
      chk(fault_lvl == 2'(m_lvl), (m_lvl == 1) ? "R4" : "R5", "fault_lvl", 32'(fault_lvl), 32'(m_lvl));
    end
    if (ph == 5) begin
      chk(fault == 1'b0 && fault_lvl == 2'd0, "R6", "no fault", {30'h0, fault_lvl} | 32'(fault), 32'h0);
      chk(pa == m_pa, "R6", "pa", pa, m_pa);
      chk(perm_wr == m_w && perm_dirty == m_d, "R6", "perm", {30'h0, perm_dirty, perm_wr}, {30'h0, m_d, m_w});
    end
  end

  // one walk; optional stray response in the issue cycle and requests while busy
  task automatic walk(input logic [31:0] va, input logic [31:0] base, input int l,
                      input bit stray_rd1, input bit busy_req,
                      input bit exp_fault, input logic [1:0] exp_lvl,
                      input logic [31:0] exp_pa, input string tag);
    lat = l;
    @(negedge clk); #1;
    walk_va = va; pt_base = base; walk_req = 1'b1;
    @(negedge clk); #1;
    walk_req = 1'b0;
    stray = stray_rd1;
    if (busy_req) begin
      walk_va = ~va; pt_base = base + 32'h40; walk_req = 1'b1;
      repeat (3) @(negedge clk);
      #1; walk_req = 1'b0; walk_va = va; pt_base = base;
    end
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (done) break;
    end
    chk(done == 1'b1, tag, "walk end", 32'(done), 32'd1);
    chk(fault == exp_fault && fault_lvl == exp_lvl, tag, "outcome",
        {30'h0, fault_lvl} | (32'(fault) << 8), {30'h0, exp_lvl} | (32'(exp_fault) << 8));
    if (!exp_fault) chk(pa == exp_pa, tag, "pa", pa, exp_pa);
    @(negedge clk);
  endtask

  localparam logic [31:0] B = 32'h0010_0000;

  initial begin
    mem[B + 32'd12]          = pte(20'h00200, 0, 0);
    mem[32'h0020_0000 + 20]  = pte(20'h12345, 0, 1);
    mem[B + 32'hFFC]         = pte(20'h00ABC, 1, 1);
    mem[32'h00AB_CFFC]       = pte(20'hFEDCB, 1, 0);
    mem[B]                   = pte(20'h00300, 0, 0);
    mem[32'h0030_0000]       = pte(20'h0000A, 1, 1);
    mem[B + 32'h20]          = 32'hFFFF_F006;

    #1;
    // R1: values held during reset
    chk(walk_ready == 1 && mem_req == 0 && done == 0 && fault == 0, "R1", "in reset",
        {28'h0, walk_ready, mem_req, done, fault}, 32'h8);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(walk_ready == 1 && mem_req == 0 && done == 0 && fault == 0, "R1", "after reset",
        {28'h0, walk_ready, mem_req, done, fault}, 32'h8);

    walk({10'd3, 10'd5, 12'hABC}, B, 1, 0, 0, 0, 2'd0, 32'h1234_5ABC, "R6");
    walk({10'd7, 10'd1, 12'h000}, B, 1, 0, 0, 1, 2'd1, 32'h0, "R4");
    walk({10'd3, 10'd6, 12'h123}, B, 2, 0, 0, 1, 2'd2, 32'h0, "R5");
    walk({10'd1023, 10'd1023, 12'hFFF}, B, 3, 0, 0, 0, 2'd0, 32'hFEDC_BFFF, "R3");
    walk({10'd8, 10'd0, 12'h000}, B, 1, 0, 0, 1, 2'd1, 32'h0, "R4");
    walk({10'd3, 10'd5, 12'h010}, B, 2, 0, 1, 0, 2'd0, 32'h1234_5010, "R7");

    // R8: a response pulse in idle changes nothing
    @(negedge clk); #1; stray = 1'b1;
    repeat (3) @(negedge clk);
    chk(walk_ready == 1 && done == 0 && mem_req == 0, "R8", "idle stray",
        {29'h0, walk_ready, done, mem_req}, 32'h4);
    walk({10'd0, 10'd0, 12'h001}, B, 1, 1, 0, 0, 2'd0, 32'h0000_A001, "R8");
    walk({10'd3, 10'd5, 12'hFFF}, B, 3, 1, 1, 0, 2'd0, 32'h1234_5FFF, "R7");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule